// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits on the bus side of a processor core and keeps a short first-in first-out queue of upcoming code bytes. Whenever the queue has room it starts a code fetch on a 16-bit memory port, so memory reads run while the execution side is still busy with earlier bytes. The two sides behave like a two-stage pipeline. The decode side takes bytes one at a time, in order, through a valid/ready handshake.

A fetch is a read of either one byte or one aligned word. Its address is the code segment value shifted left by four bits plus a 16-bit fetch offset, and the offset advances after every fetch. When the offset is odd, one byte is fetched first so that every later fetch is word-aligned. A flush input, raised for a taken branch, empties the queue in one cycle, loads a new fetch offset and throws away the data of any fetch that was still in flight.

Top module: `code_prefetch_queue`

## Requirements
- R1: While reset is held, and in the first cycle after it, `dec_valid_o` and `mem_req_o` are low. After reset the fetch offset is 0, so the first request is a word read at physical address `seg_i*16`.
- R2: The queue holds at most 6 bytes. When no bytes are popped, fetching stops once 6 bytes are held, and `mem_req_o` stays low.
- R3: A word request is started only when at least 2 slots are free. A byte request is started only when at least 1 slot is free. With one slot free and an even offset, no request is made.
- R4: `mem_addr_o` equals `{seg_i, 4'b0000} + offset`, taken modulo 2^20.
- R5: A request at an odd offset is a byte request (`mem_word_o`=0), and its byte is taken from `mem_rdata_i[15:8]`. Every word request (`mem_word_o`=1) has an even address.
- R6: For a word request, `mem_rdata_i[7:0]` enters the queue before `mem_rdata_i[15:8]`, and bytes leave the queue in the order they entered.
- R7: Only one request is open at a time. `mem_req_o`, `mem_addr_o` and `mem_word_o` hold steady until the cycle in which `mem_ack_i` is high, and that cycle completes the request.
- R8: A cycle with `flush_i` high empties the queue, so `dec_valid_o` is low in the next cycle. Fetching then continues from `flush_off_i`.
- R9: The data of a request that is open when `flush_i` is high, including one acknowledged in that same cycle, never enters the queue. The handshake still completes.
- R10: A byte pushed and a byte popped in the same cycle both take effect, and no byte is lost or repeated.
- R11: `dec_valid_o` is low whenever the queue is empty. `dec_ready_i` has no effect while the queue is empty.
- R12: The offset advances by 1 after a byte request and by 2 after a word request. It wraps from 16'hFFFF to 16'h0000 inside the segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_i | input | 16 | Code segment value, used as the base of every fetch address |
| flush_i | input | 1 | Empty the queue and restart fetching at `flush_off_i` |
| flush_off_i | input | 16 | New fetch offset, loaded when `flush_i` is high |
| mem_req_o | output | 1 | Fetch request, held until acknowledged |
| mem_word_o | output | 1 | 1 = word read, 0 = single-byte read |
| mem_addr_o | output | 20 | Physical byte address of the fetch |
| mem_ack_i | input | 1 | Fetch complete; `mem_rdata_i` is valid in this cycle |
| mem_rdata_i | input | 16 | Fetch data; the even byte is on [7:0] and the odd byte on [15:8] |
| dec_valid_o | output | 1 | The queue head holds a byte |
| dec_byte_o | output | 8 | Byte at the queue head |
| dec_ready_i | input | 1 | Decoder takes the head byte in this cycle |

## Verification
A wrong occupancy count shows up at the ports within a few cycles. If it is too high, requests stop early and the queue settles on fewer bytes than the fetch log predicts. If it is too low, an extra request is issued after a fetch that should have been the last one. A wrong read or write index, or a wrong lane choice for an odd byte, puts a wrong or stale value on `dec_byte_o` at the very next pop, so each popped byte is compared with a function of its physical address. A flush that fails to drop in-flight data shows up as a byte from the old stream at the first pop after the redirect.

// File: rtl/pq_pkg.sv
package pq_pkg;

    // Phases of the single outstanding code fetch.
    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;

    // Number of bytes a fetch delivers, given the low bit of its offset.
    function automatic logic [1:0] fetch_bytes(input logic odd);
        return odd ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/pq_byte_store.sv
module pq_byte_store #(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [1:0]       push_n_i,
    input  logic [7:0]       push_b0_i,
    input  logic [7:0]       push_b1_i,
    input  logic             pop_i,
    output logic [7:0]       head_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      rd;
        logic [PTR_W-1:0]      wr;
        logic [CNT_W-1:0]      cnt;
    } store_t;

    store_t s_q, s_d;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic             pop_eff;
    logic [PTR_W-1:0] wr_next1;

    always_comb begin
        s_d      = s_q;
        pop_eff  = pop_i && (s_q.cnt != '0);
        wr_next1 = step(s_q.wr);
        if (clear_i) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (push_n_i != 2'd0) begin
                s_d.mem[s_q.wr] = push_b0_i;
            end
            if (push_n_i == 2'd2) begin
                s_d.mem[wr_next1] = push_b1_i;
            end
            case (push_n_i)
                2'd1:    s_d.wr = wr_next1;
                2'd2:    s_d.wr = step(wr_next1);
                default: s_d.wr = s_q.wr;
            endcase
            if (pop_eff) begin
                s_d.rd = step(s_q.rd);
            end
            s_d.cnt = s_q.cnt + CNT_W'(push_n_i) - CNT_W'(pop_eff);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_o  = s_q.mem[s_q.rd];
    assign valid_o = (s_q.cnt != '0);
    assign count_o = s_q.cnt;

    // R2: occupancy never exceeds the storage depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R8: a clear leaves nothing in the queue
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (s_q.cnt == '0));

    // R11: a pop request on an empty queue changes nothing
    a_r11_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0 && push_n_i == 2'd0 && !clear_i) |=> (s_q.cnt == '0) && $stable(s_q.rd));

endmodule

// File: rtl/pq_fetch_seq.sv
module pq_fetch_seq
    import pq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int OFF_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [OFF_W-1:0] flush_off_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             mem_ack_i,
    output logic             req_o,
    output logic [OFF_W-1:0] req_off_o,
    output logic             req_word_o,
    output logic [1:0]       push_n_o
);
    typedef struct packed {
        fetch_state_e     st;
        logic [OFF_W-1:0] ptr;
        logic [OFF_W-1:0] req_off;
        logic             req_word;
        logic             drop;
    } fetch_t;

    fetch_t s_q, s_d;

    logic [CNT_W-1:0] free_slots;
    logic [CNT_W-1:0] need_slots;
    logic [1:0]       push_n;

    always_comb begin
        s_d        = s_q;
        push_n     = 2'd0;
        free_slots = CNT_W'(DEPTH) - count_i;
        need_slots = CNT_W'(fetch_bytes(s_q.ptr[0]));

        // Completion of the open request.
        if (s_q.st == FS_WAIT && mem_ack_i) begin
            s_d.st   = FS_IDLE;
            s_d.drop = 1'b0;
            if (!s_q.drop && !flush_i) begin
                push_n = s_q.req_word ? 2'd2 : 2'd1;
            end
        end

        if (flush_i) begin
            s_d.ptr = flush_off_i;
            if (s_q.st == FS_WAIT && !mem_ack_i) begin
                s_d.drop = 1'b1;
            end
        end else if (s_q.st == FS_IDLE && free_slots >= need_slots) begin
            s_d.st       = FS_WAIT;
            s_d.req_off  = s_q.ptr;
            s_d.req_word = !s_q.ptr[0];
            s_d.ptr      = s_q.ptr + OFF_W'(fetch_bytes(s_q.ptr[0]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: FS_IDLE, ptr: '0, req_off: '0, req_word: 1'b0, drop: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o      = (s_q.st == FS_WAIT);
    assign req_off_o  = s_q.req_off;
    assign req_word_o = s_q.req_word;
    assign push_n_o   = push_n;

    // R7: an open request holds its offset and size until acknowledged
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !mem_ack_i) |=> req_o && $stable(req_off_o) && $stable(req_word_o));

    // R5: word requests are always at even offsets
    a_r5_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && req_word_o) |-> !req_off_o[0]);

    // R9: nothing is pushed in a flush cycle
    a_r9_flush_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (push_n_o == 2'd0));

endmodule

// File: rtl/code_prefetch_queue.sv
module code_prefetch_queue #(
    parameter int DEPTH     = 6,
    parameter int OFF_W     = 16,
    parameter int SEG_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SEG_W-1:0]           seg_i,
    input  logic                       flush_i,
    input  logic [OFF_W-1:0]           flush_off_i,
    output logic                       mem_req_o,
    output logic                       mem_word_o,
    output logic [SEG_W+SEG_SHIFT-1:0] mem_addr_o,
    input  logic                       mem_ack_i,
    input  logic [15:0]                mem_rdata_i,
    output logic                       dec_valid_o,
    output logic [7:0]                 dec_byte_o,
    input  logic                       dec_ready_i
);
    localparam int ADDR_W = SEG_W + SEG_SHIFT;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] count;
    logic [OFF_W-1:0] req_off;
    logic             req_word;
    logic [1:0]       push_n;
    logic [7:0]       push_b0;
    logic [7:0]       push_b1;

    pq_fetch_seq #(
        .DEPTH (DEPTH),
        .OFF_W (OFF_W),
        .CNT_W (CNT_W)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .flush_off_i (flush_off_i),
        .count_i     (count),
        .mem_ack_i   (mem_ack_i),
        .req_o       (mem_req_o),
        .req_off_o   (req_off),
        .req_word_o  (req_word),
        .push_n_o    (push_n)
    );

    // Odd-address bytes arrive on the high lane.
    assign push_b0 = req_word ? mem_rdata_i[7:0] : mem_rdata_i[15:8];
    assign push_b1 = mem_rdata_i[15:8];

    pq_byte_store #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush_i),
        .push_n_i  (push_n),
        .push_b0_i (push_b0),
        .push_b1_i (push_b1),
        .pop_i     (dec_ready_i),
        .head_o    (dec_byte_o),
        .valid_o   (dec_valid_o),
        .count_o   (count)
    );

    assign mem_word_o = req_word;
    assign mem_addr_o = {seg_i, {SEG_SHIFT{1'b0}}} + ADDR_W'(req_off);

    // R8: the cycle after a flush shows an empty queue
    a_r8_flush_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !dec_valid_o);

    // R3: accepted fetch data always fits in the free slots
    a_r3_push_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0) |-> ((count + CNT_W'(push_n)) <= CNT_W'(DEPTH)));

    // R1: no request is raised in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !mem_req_o && !dec_valid_o);

endmodule

// File: tb/test_code_prefetch_queue.sv
module test_code_prefetch_queue;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] seg;
    logic        flush;
    logic [15:0] flush_off;
    logic        mem_req;
    logic        mem_word;
    logic [19:0] mem_addr;
    logic        mem_ack;
    logic [15:0] mem_rdata;
    logic        dec_valid;
    logic [7:0]  dec_byte;
    logic        dec_ready;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    code_prefetch_queue i_code_prefetch_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .seg_i       (seg),
        .flush_i     (flush),
        .flush_off_i (flush_off),
        .mem_req_o   (mem_req),
        .mem_word_o  (mem_word),
        .mem_addr_o  (mem_addr),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .dec_valid_o (dec_valid),
        .dec_byte_o  (dec_byte),
        .dec_ready_i (dec_ready)
    );

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'b0000} + {4'b0000, o};
    endfunction

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'h96;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory responder: samples and drives on the falling edge.
    int          lat = 0;
    int          wcnt = 0;
    logic [19:0] held_addr;
    logic        held_word;
    bit          unstable = 0;
    logic [19:0] log_addr [0:63];
    logic        log_word [0:63];
    int          log_n = 0;

    initial begin
        mem_ack   = 1'b0;
        mem_rdata = 16'h0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                wcnt    = 0;
            end else if (mem_req) begin
                if (wcnt == 0) begin
                    held_addr = mem_addr;
                    held_word = mem_word;
                end else if (mem_addr != held_addr || mem_word != held_word) begin
                    unstable = 1;
                end
                if (wcnt >= lat) begin
                    mem_ack = 1'b1;
                    if (mem_word) mem_rdata = {mem_byte(mem_addr + 20'd1), mem_byte(mem_addr)};
                    else          mem_rdata = {mem_byte(mem_addr), 8'hEE};
                    if (log_n < 64) begin
                        log_addr[log_n] = mem_addr;
                        log_word[log_n] = mem_word;
                    end
                    log_n++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    logic [15:0] exp_off;

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            while (!dec_valid) @(negedge clk);
            check(dec_byte == mem_byte(phys(seg, exp_off)), tag, dec_byte, mem_byte(phys(seg, exp_off)));
            exp_off   = exp_off + 16'd1;
            dec_ready = 1'b1;
            @(negedge clk);
            dec_ready = 1'b0;
        end
    endtask

    task automatic do_flush(input logic [15:0] off);
        flush     = 1'b1;
        flush_off = off;
        exp_off   = off;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        check(!dec_valid, "R1 valid in reset", dec_valid, 0);
        check(!mem_req, "R1 req in reset", mem_req, 0);
        log_n = 0;
        exp_off = 16'h0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!dec_valid, "R1 valid after reset", dec_valid, 0);
        idle(2);
        check(log_n >= 1 && log_addr[0] == phys(seg, 16'h0) && log_word[0], "R1 R4 first request", log_addr[0], phys(seg, 16'h0));
    endtask

    task automatic t_fill_and_space;
        idle(30);
        check(log_n == 3, "R2 fetch count when full", log_n, 3);
        check(!mem_req, "R2 no request when full", mem_req, 0);
        check(log_addr[1] == phys(seg, 16'h2) && log_addr[2] == phys(seg, 16'h4), "R12 word steps", log_addr[2], phys(seg, 16'h4));
        drain(1, "R6 first byte");
        idle(10);
        check(log_n == 3 && !mem_req, "R3 one free slot blocks word", log_n, 3);
        drain(1, "R6 second byte");
        idle(10);
        check(log_n == 4 && log_addr[3] == phys(seg, 16'h6), "R3 two free slots start word", log_addr[3], phys(seg, 16'h6));
        drain(6, "R6 byte order");
    endtask

    task automatic t_odd_start;
        idle(30);
        seg   = 16'h1234;
        log_n = 0;
        do_flush(16'h0013);
        idle(30);
        check(log_addr[0] == 20'h12353 && !log_word[0], "R5 odd start byte request", log_addr[0], 20'h12353);
        check(log_addr[1] == 20'h12354 && log_word[1], "R5 aligned word next", log_addr[1], 20'h12354);
        check(log_n == 3, "R3 five bytes held, no word", log_n, 3);
        drain(12, "R5 odd start stream");
    endtask

    task automatic t_flush_inflight;
        idle(30);
        lat = 6;
        drain(2, "R6 pre-flush bytes");
        while (!mem_req) @(negedge clk);
        log_n    = 0;
        unstable = 0;
        do_flush(16'h0200);
        check(!dec_valid, "R8 empty after flush", dec_valid, 0);
        idle(60);
        check(log_n >= 2 && log_addr[0] != phys(seg, 16'h0200), "R9 old handshake completes", log_addr[0], 0);
        check(log_addr[1] == phys(seg, 16'h0200), "R8 refetch at new offset", log_addr[1], phys(seg, 16'h0200));
        check(!unstable, "R7 request held stable", unstable, 0);
        drain(6, "R9 no stale bytes");
    endtask

    task automatic t_stream;
        lat = 0;
        idle(30);
        do_flush(16'h0400);
        drain(40, "R10 push and pop together");
    endtask

    task automatic t_empty_pop;
        idle(30);
        lat = 4;
        dec_ready = 1'b1;
        flush     = 1'b1;
        flush_off = 16'h0600;
        exp_off   = 16'h0600;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check(!dec_valid, "R11 valid low when empty", dec_valid, 0);
            @(negedge clk);
        end
        dec_ready = 1'b0;
        idle(20);
        drain(6, "R11 ready ignored when empty");
        lat = 0;
    endtask

    task automatic t_wrap;
        idle(30);
        seg   = 16'hFFFF;
        log_n = 0;
        do_flush(16'hFFFD);
        idle(30);
        check(log_addr[0] == 20'h0FFED && !log_word[0], "R4 address wraps modulo 2^20", log_addr[0], 20'h0FFED);
        check(log_addr[1] == 20'h0FFEE && log_word[1], "R12 word after byte", log_addr[1], 20'h0FFEE);
        check(log_addr[2] == 20'hFFFF0, "R12 offset wraps to zero", log_addr[2], 20'hFFFF0);
        drain(10, "R12 wrapped stream");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        seg       = 16'h2000;
        flush     = 1'b0;
        flush_off = 16'h0;
        dec_ready = 1'b0;
        exp_off   = 16'h0;
        idle(2);
        t_reset();
        t_fill_and_space();
        t_odd_start();
        t_flush_inflight();
        t_stream();
        t_empty_pop();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule